// File: doc/BRIEF.md
# External Bus Address-Latch and Code-Read Strobe Generator

This block produces the two timing strobes of an 8-bit microcontroller's multiplexed external bus. The first is a high-active address-latch strobe. The second is a low-active code-read strobe. A machine cycle is 12 oscillator clocks long. A free-running phase counter divides each cycle into two halves of six clocks, and every strobe pulse sits at a fixed phase within its half. With no special conditions, the latch strobe runs at one sixth of the oscillator rate.

At the start of each machine cycle, the block samples four things:
- a flag that marks the cycle as an external data-memory access;
- a flag for a data-move or code-table instruction in progress;
- a flag for execution from external program memory;
- a one-bit latch-disable setting, written through a write-enable port.

For the rest of the cycle, these samples decide the output:
- A data-memory cycle loses its second latch pulse and both code-read pulses.
- The latch-disable setting silences the latch strobe. It has no effect while a data-move or code-table instruction runs, or while code runs from external memory.

The CPU sequencer drives the flags. The block does not multiplex address or data.

Top module: `xbus_strobe`

## Requirements
- R1: During reset and after it, `ale` is 0, `psen_n` is 1 and the latch-disable setting is 0. The first rising clock edge with `rst` low starts a machine cycle at phase 0. Phases then run 0 to 11 and wrap.
- R2: When the latch strobe is allowed and the cycle is not a data-memory cycle, `ale` is 1 during phases 0–1 and 6–7 and 0 in all other phases. This gives two pulses of two clocks each per machine cycle.
- R3: In a data-memory cycle (`xdata_cyc` = 1 when sampled), the `ale` pulse at phases 6–7 is omitted. The pulse at phases 0–1 is kept when the strobe is allowed.
- R4: When `ext_fetch` = 1 and the cycle is not a data-memory cycle, `psen_n` is 0 during phases 3–5 and 9–11 and 1 otherwise. When `ext_fetch` = 0, `psen_n` stays 1.
- R5: In a data-memory cycle, `psen_n` stays 1 for the whole cycle, even when `ext_fetch` = 1.
- R6: With the latch-disable setting at 1, and both `xfer_instr` and `ext_fetch` at 0, `ale` stays 0 for the whole machine cycle.
- R7: With the latch-disable setting at 1 and `xfer_instr` = 1, `ale` pulses as in R2 and R3.
- R8: With the latch-disable setting at 1 and `ext_fetch` = 1, `ale` pulses as in R2 and R3.
- R9: `xdata_cyc`, `xfer_instr` and `ext_fetch` are sampled only on the edge that enters phase 0. Changes later in the cycle have no effect until the next cycle.
- R10: A clock edge with `cfg_we` = 1 loads `cfg_ale_off` into the latch-disable setting. The new value first applies to the machine cycle that starts after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| xdata_cyc | input | 1 | Marks the coming machine cycle as an external data-memory access |
| xfer_instr | input | 1 | A data-move or code-table instruction is in progress |
| ext_fetch | input | 1 | Code is executing from external program memory |
| cfg_we | input | 1 | Write enable for the latch-disable setting |
| cfg_ale_off | input | 1 | Value written into the latch-disable setting |
| ale | output | 1 | Address-latch strobe, active high |
| psen_n | output | 1 | Code-read strobe, active low |

## Verification
The latch-disable setting and the data-memory pulse skip can both act on the same machine cycle. In the test, the setting is written to 1 and then held. Cycles are then run with `xdata_cyc` raised together with either `xfer_instr` or `ext_fetch`. Each such cycle must show exactly one latch pulse, at phases 0–1, and no code-read pulse. A second test overlaps mid-cycle input changes with a write to the setting. These cycles are judged against the values sampled at phase 0, and the write must apply only from the following cycle.

// File: rtl/xbus_strobe.sv
module xbus_strobe #(
  parameter int CYC_LEN  = 12,
  parameter int ALE_W    = 2,
  parameter int PSEN_OFS = 3,
  parameter int PSEN_W   = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic xdata_cyc,
  input  logic xfer_instr,
  input  logic ext_fetch,
  input  logic cfg_we,
  input  logic cfg_ale_off,
  output logic ale,
  output logic psen_n
);
  localparam int PW = $clog2(CYC_LEN);
  localparam logic [PW-1:0] LAST   = PW'(CYC_LEN - 1);
  localparam logic [PW-1:0] HALFV  = PW'(CYC_LEN / 2);
  localparam logic [PW-1:0] ALE_E  = PW'(ALE_W);
  localparam logic [PW-1:0] PS_B   = PW'(PSEN_OFS);
  localparam logic [PW-1:0] PS_E   = PW'(PSEN_OFS + PSEN_W);

  logic [PW-1:0] ph, ph_nxt, pos_nxt;
  logic          ale_off, ale_off_nxt;
  logic          dmem_q, ok_q, fetch_q;
  logic          dmem_nxt, ok_nxt, fetch_nxt, upper_nxt, boundary;

  assign boundary    = (ph == LAST);
  assign ph_nxt      = boundary ? '0 : ph + PW'(1);
  assign ale_off_nxt = cfg_we ? cfg_ale_off : ale_off;

  assign dmem_nxt  = boundary ? xdata_cyc : dmem_q;
  assign fetch_nxt = boundary ? ext_fetch : fetch_q;
  assign ok_nxt    = boundary ? (!ale_off || xfer_instr || ext_fetch) : ok_q;

  assign upper_nxt = (ph_nxt >= HALFV);
  assign pos_nxt   = upper_nxt ? ph_nxt - HALFV : ph_nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph      <= LAST;
      ale_off <= 1'b0;
      dmem_q  <= 1'b0;
      ok_q    <= 1'b0;
      fetch_q <= 1'b0;
      ale     <= 1'b0;
      psen_n  <= 1'b1;
    end else begin
      ph      <= ph_nxt;
      ale_off <= ale_off_nxt;
      dmem_q  <= dmem_nxt;
      ok_q    <= ok_nxt;
      fetch_q <= fetch_nxt;
      ale     <= ok_nxt && (pos_nxt < ALE_E) && !(upper_nxt && dmem_nxt);
      psen_n  <= !(fetch_nxt && !dmem_nxt && (pos_nxt >= PS_B) && (pos_nxt < PS_E));
    end
  end
endmodule

// File: rtl/xbus_strobe_chk.sv
module xbus_strobe_chk #(
  parameter int CYC_LEN = 12
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       xdata_cyc,
  input logic                       xfer_instr,
  input logic                       ext_fetch,
  input logic                       cfg_we,
  input logic                       cfg_ale_off,
  input logic                       ale,
  input logic                       psen_n,
  input logic [$clog2(CYC_LEN)-1:0] ph
);
  localparam int PW = $clog2(CYC_LEN);
  localparam logic [PW-1:0] LAST  = PW'(CYC_LEN - 1);
  localparam logic [PW-1:0] HALFV = PW'(CYC_LEN / 2);

  logic c_dm, c_fe, c_gate, c_off;

  always_ff @(posedge clk) begin
    if (rst) begin
      c_dm <= 1'b0; c_fe <= 1'b0; c_gate <= 1'b0; c_off <= 1'b0;
    end else begin
      if (cfg_we) c_off <= cfg_ale_off;
      if (ph == LAST) begin
        c_dm   <= xdata_cyc;
        c_fe   <= ext_fetch;
        c_gate <= !c_off || xfer_instr || ext_fetch;
      end
    end
  end

  // R1
  ale_phase_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ale) |-> (ph == '0 || ph == HALFV));
  // R2
  ale_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ale) |=> ale);
  // R3
  dmem_skip_chk: assert property (@(posedge clk) disable iff (rst)
    (c_dm && ph >= HALFV) |-> !ale);
  // R4
  psen_int_chk: assert property (@(posedge clk) disable iff (rst)
    !c_fe |-> psen_n);
  // R4
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !psen_n |-> !ale);
  // R5
  psen_dmem_chk: assert property (@(posedge clk) disable iff (rst)
    c_dm |-> psen_n);
  // R6
  ale_off_chk: assert property (@(posedge clk) disable iff (rst)
    !c_gate |-> !ale);
endmodule

bind xbus_strobe xbus_strobe_chk #(.CYC_LEN(CYC_LEN)) u_chk (
  .clk(clk), .rst(rst), .xdata_cyc(xdata_cyc), .xfer_instr(xfer_instr),
  .ext_fetch(ext_fetch), .cfg_we(cfg_we), .cfg_ale_off(cfg_ale_off),
  .ale(ale), .psen_n(psen_n), .ph(ph)
);

// File: tb/xbus_strobe_bench.sv
module xbus_strobe_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic xdata_cyc = 1'b0, xfer_instr = 1'b0, ext_fetch = 1'b0;
  logic cfg_we = 1'b0, cfg_ale_off = 1'b0;
  logic ale, psen_n;

  always #2.5 clk = ~clk;

  xbus_strobe u_xbus_strobe (
    .clk(clk), .rst(rst), .xdata_cyc(xdata_cyc), .xfer_instr(xfer_instr),
    .ext_fetch(ext_fetch), .cfg_we(cfg_we), .cfg_ale_off(cfg_ale_off),
    .ale(ale), .psen_n(psen_n)
  );

  typedef struct {
    logic  a;
    logic  p;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   errors = 0;
  int   checks = 0;
  bit   done = 1'b0;
  bit   model_off = 1'b0;

  always @(posedge clk) begin
    exp_t e;
    #1;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      checks++;
      if (ale !== e.a || psen_n !== e.p) begin
        errors++;
        $display("FAIL %s: ale=%b psen_n=%b expected ale=%b psen_n=%b",
                 e.tag, ale, psen_n, e.a, e.p);
      end
    end
  end

  task automatic idle_check(input string tag);
    checks++;
    if (ale !== 1'b0 || psen_n !== 1'b1) begin
      errors++;
      $display("FAIL %s: ale=%b psen_n=%b expected ale=0 psen_n=1", tag, ale, psen_n);
    end
  endtask

  // Entered at a falling edge while the design sits in its last phase.
  task automatic run_cycle(input bit dm, input bit mv, input bit ex,
                           input bit flip, input bit wr, input bit wv,
                           input string tag);
    bit gate;
    exp_t e;
    xdata_cyc = dm; xfer_instr = mv; ext_fetch = ex;
    gate = !model_off || mv || ex;
    for (int p = 0; p < 12; p++) begin
      int pos;
      bit up;
      up  = (p >= 6);
      pos = p % 6;
      e.a   = gate && (pos < 2) && !(up && dm);
      e.p   = !(ex && !dm && pos >= 3 && pos < 6);
      e.tag = tag;
      exp_q.push_back(e);
    end
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (k == 2 && wr) begin cfg_we = 1'b1; cfg_ale_off = wv; end
      if (k == 3) begin
        cfg_we = 1'b0;
        if (flip) begin
          xdata_cyc = !dm; xfer_instr = !mv; ext_fetch = !ex;
        end
      end
    end
    if (wr) model_off = wv;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    idle_check("R1 in reset");
    rst = 1'b0;
    run_cycle(0, 0, 0, 0, 0, 0, "R1 first cycle");
    run_cycle(0, 0, 0, 0, 0, 0, "R2");
    run_cycle(0, 0, 1, 0, 0, 0, "R4 ext fetch");
    run_cycle(0, 0, 1, 0, 0, 0, "R4 ext fetch repeat");
    run_cycle(1, 0, 0, 0, 0, 0, "R3");
    run_cycle(1, 0, 1, 0, 0, 0, "R5");
    run_cycle(0, 0, 0, 0, 1, 1, "R10 write not yet applied");
    run_cycle(0, 0, 0, 0, 0, 0, "R6");
    run_cycle(0, 1, 0, 0, 0, 0, "R7");
    run_cycle(0, 0, 1, 0, 0, 0, "R8");
    run_cycle(1, 1, 0, 0, 0, 0, "R3 R7 dmem with disable");
    run_cycle(1, 0, 1, 0, 0, 0, "R5 R8 dmem with disable");
    run_cycle(0, 0, 0, 1, 0, 0, "R9 disabled, flip mid-cycle");
    run_cycle(0, 0, 0, 0, 1, 0, "R10 clear not yet applied");
    run_cycle(1, 0, 1, 1, 0, 0, "R9 flip mid-cycle");
    run_cycle(0, 0, 1, 0, 1, 1, "R8 R10 write during ext");
    run_cycle(0, 0, 0, 0, 0, 0, "R6 after second write");
    rst = 1'b1;
    repeat (2) @(negedge clk);
    idle_check("R1 re-reset");
    rst = 1'b0;
    model_off = 1'b0;
    run_cycle(0, 0, 0, 0, 0, 0, "R1 disable cleared by reset");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog (R1-level sequencing): run not finished, expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule